// File: doc/BRIEF.md
# Read-Only Port to ISA I/O Bridge

This block lets a host reach a small ISA I/O peripheral through an expansion port on which the host can only issue read cycles. Every qualified host access becomes one ISA I/O cycle. The ISA register select comes from a group of host address bits, and the upper ISA address bits are fixed so that the peripheral sees an I/O base of 0x300. The window line, which is host address bit 16, decides the cycle type. A low window line gives an ISA read. A high window line, which is the window 0x10000 above, gives an ISA write. Write data cannot travel on the host data bus, so the host puts the data byte on address bits 8..1 and the bridge drives it onto the ISA data lines.

A mode input picks between a byte-wide peripheral and a 16-bit peripheral. In byte mode every transfer is one byte, and read data comes back on host data bits 15..8. In word mode a read returns all 16 peripheral bits in one access. A word write takes two host accesses. A low-window access parks its address byte in a holding register. The next high-window access then issues a single 16-bit ISA write, with its own address byte as the high half and the parked byte as the low half.

Each ISA strobe is asserted for a fixed number of clocks. Address and data settle one clock before the strobe falls. There is one clock of hold after the strobe rises, and only then does the bridge enable the host data bus. The bus stays enabled until the host drops its select.

Top module: `cpisa_bridge`

## Requirements
- R1: While reset is applied, and on leaving it, both ISA strobes are high (inactive), the ISA data drive enable is low and the host output enable is low. Reset also empties the low-byte holding register.
- R2: During every ISA strobe the ISA address equals 0x300 plus host address bits 13..9. Host address bit 9 maps to ISA address bit 0.
- R3: With host_win low the access produces an ISA read strobe (isa_ior_n low). With host_win high it produces an ISA write strobe (isa_iow_n low). The two strobes are never low together.
- R4: In byte mode (host_word_mode = 0), a read returns the peripheral's isa_din[7:0] on host_rdata[15:8] and zero on host_rdata[7:0]. isa_wide stays low.
- R5: In byte mode, a write drives host address bits 8..1 on isa_dout[7:0], with isa_dout_en high while isa_iow_n is low, and isa_wide low. The host read of that access returns the same byte on host_rdata[15:8] and zero on host_rdata[7:0].
- R6: Each strobe stays low for exactly PULSE_CLKS clocks. The ISA address and data hold the values they showed in the clock before the strobe fell, for as long as the strobe is low. host_oe rises exactly two clocks after the last strobe-low clock, which leaves one clock of hold.
- R7: In word mode a low-window access performs a 16-bit ISA read with isa_wide high and returns isa_din[15:0] unchanged on host_rdata.
- R8: In word mode a low-window access loads host address bits 8..1 into the holding register. The next high-window access performs one 16-bit ISA write of {host address bits 8..1, held byte} with isa_wide high. Its host read returns the high byte on host_rdata[15:8].
- R9: A completed word write empties the holding register. A word write made while the register is empty uses 0x00 for the low byte.
- R10: host_oe stays high, and no further ISA cycle starts, for as long as host_sel and host_stb both stay high after completion. host_oe falls one clock after the host releases them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host port select, active high |
| host_stb | input | 1 | Host address strobe, active high; a cycle starts when both are high |
| host_win | input | 1 | Host address bit 16: 0 = read window, 1 = write window |
| host_addr | input | 13 | Host address bits 13..1: 13..9 register select, 8..1 data byte |
| host_word_mode | input | 1 | 0 = byte peripheral, 1 = 16-bit peripheral |
| host_rdata | output | 16 | Data returned to the host |
| host_oe | output | 1 | Host data bus enable; high once the ISA cycle is complete |
| isa_addr | output | 10 | ISA I/O address |
| isa_dout | output | 16 | ISA write data |
| isa_dout_en | output | 1 | ISA data bus drive enable |
| isa_din | input | 16 | ISA read data |
| isa_ior_n | output | 1 | ISA I/O read strobe, active low |
| isa_iow_n | output | 1 | ISA I/O write strobe, active low |
| isa_wide | output | 1 | High during a 16-bit ISA transfer |

## Verification
The bench builds the bridge with PULSE_CLKS = 3, which is shorter than the default, so that the strobe width count, the setup check and the two-clock gap to host_oe are measured on a pulse the run can afford at every access. The register select, the fixed 0x300 base and the holding register keep their default widths. This keeps all 32 ISA register addresses and every data byte pattern reachable. It also brings a reset applied while a low byte is parked into reach, which shows that the holding register is emptied.

// File: rtl/cpisa_pkg.sv
package cpisa_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_SETUP  = 3'd1,
    SQ_STROBE = 3'd2,
    SQ_HOLD   = 3'd3,
    SQ_DONE   = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    AK_BYTE_RD = 2'd0,
    AK_BYTE_WR = 2'd1,
    AK_WORD_RD = 2'd2,
    AK_WORD_WR = 2'd3
  } access_kind_t;

endpackage

// File: rtl/cpisa_decode.sv
module cpisa_decode #(
  parameter int REG_W    = 5,
  parameter int BYTE_W   = 8,
  parameter int ISA_AW   = 10,
  parameter logic [ISA_AW-1:0] IO_BASE = 10'h300
) (
  input  logic [REG_W+BYTE_W-1:0]  addr_bits,
  input  logic                     win,
  input  logic                     word_mode,
  output cpisa_pkg::access_kind_t  kind,
  output logic [BYTE_W-1:0]        data_byte,
  output logic [ISA_AW-1:0]        isa_addr_next
);
  import cpisa_pkg::*;

  localparam int BASE_HI_W = ISA_AW - REG_W;

  logic [REG_W-1:0] reg_sel;

  always_comb begin
    data_byte     = addr_bits[BYTE_W-1:0];
    reg_sel       = addr_bits[REG_W+BYTE_W-1:BYTE_W];
    isa_addr_next = {IO_BASE[ISA_AW-1:REG_W], reg_sel};
    unique case ({word_mode, win})
      2'b00:   kind = AK_BYTE_RD;
      2'b01:   kind = AK_BYTE_WR;
      2'b10:   kind = AK_WORD_RD;
      default: kind = AK_WORD_WR;
    endcase
  end

  initial begin
    if (BASE_HI_W < 1) $error("ISA_AW must exceed REG_W");
  end

endmodule

// File: rtl/cpisa_wbuf.sv
module cpisa_wbuf #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              commit,
  output logic [BYTE_W-1:0] low_byte,
  output logic              valid
);

  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              valid_d;
  logic              hold_en;

  always_comb begin
    hold_en = load;
    hold_d  = load_byte;
    valid_d = valid;
    if (load)        valid_d = 1'b1;
    else if (commit) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      hold_q <= '0;
    end else begin
      valid <= valid_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign low_byte = valid ? hold_q : '0;

  p_commit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !load) |=> !valid);

  p_load_parks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (valid && low_byte == $past(load_byte)));

  p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && commit));

endmodule

// File: rtl/cpisa_seq.sv
module cpisa_seq #(
  parameter int PULSE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic go,
  output logic strobe_on,
  output logic drive_on,
  output logic sample,
  output logic done
);
  import cpisa_pkg::*;

  localparam int CW = (PULSE_CLKS < 2) ? 1 : $clog2(PULSE_CLKS);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CLKS - 1);

  seq_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE:   if (req) state_d = SQ_SETUP;
      SQ_SETUP: begin
        state_d = SQ_STROBE;
        cnt_en  = 1'b1;
        cnt_d   = CNT_LOAD;
      end
      SQ_STROBE: begin
        if (cnt_q == '0) begin
          state_d = SQ_HOLD;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end
      SQ_HOLD:   state_d = SQ_DONE;
      SQ_DONE:   if (!req) state_d = SQ_IDLE;
      default:   state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign go        = (state_q == SQ_IDLE) && req;
  assign strobe_on = (state_q == SQ_STROBE);
  assign drive_on  = (state_q == SQ_SETUP) || (state_q == SQ_STROBE) || (state_q == SQ_HOLD);
  assign sample    = (state_q == SQ_STROBE) && (cnt_q == '0);
  assign done      = (state_q == SQ_DONE);

  p_wait_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req) |=> done);

  p_hold_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_on) |-> (drive_on && !done));

  p_setup_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_on) |-> $past(drive_on));

endmodule

// File: rtl/cpisa_bridge.sv
module cpisa_bridge #(
  parameter int REG_W      = 5,
  parameter int BYTE_W     = 8,
  parameter int ISA_AW     = 10,
  parameter int ISA_DW     = 16,
  parameter logic [ISA_AW-1:0] IO_BASE = 10'h300,
  parameter int PULSE_CLKS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_sel,
  input  logic                    host_stb,
  input  logic                    host_win,
  input  logic [REG_W+BYTE_W:1]   host_addr,
  input  logic                    host_word_mode,
  output logic [ISA_DW-1:0]       host_rdata,
  output logic                    host_oe,
  output logic [ISA_AW-1:0]       isa_addr,
  output logic [ISA_DW-1:0]       isa_dout,
  output logic                    isa_dout_en,
  input  logic [ISA_DW-1:0]       isa_din,
  output logic                    isa_ior_n,
  output logic                    isa_iow_n,
  output logic                    isa_wide
);
  import cpisa_pkg::*;

  localparam int HA_W = REG_W + BYTE_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  logic              req;
  logic              go, strobe_on, drive_on, sample, done;
  access_kind_t      kind;
  logic [BYTE_W-1:0] dec_byte;
  logic [ISA_AW-1:0] dec_addr;
  logic [BYTE_W-1:0] held_low;
  logic              held_valid;
  logic              wb_load, wb_commit;

  assign req = host_sel && host_stb;

  cpisa_decode #(
    .REG_W(REG_W), .BYTE_W(BYTE_W), .ISA_AW(ISA_AW), .IO_BASE(IO_BASE)
  ) u_dec (
    .addr_bits     (host_addr[HA_W:1]),
    .win           (host_win),
    .word_mode     (host_word_mode),
    .kind          (kind),
    .data_byte     (dec_byte),
    .isa_addr_next (dec_addr)
  );

  cpisa_seq #(.PULSE_CLKS(PULSE_CLKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .req       (req),
    .go        (go),
    .strobe_on (strobe_on),
    .drive_on  (drive_on),
    .sample    (sample),
    .done      (done)
  );

  assign wb_load   = go && (kind == AK_WORD_RD);
  assign wb_commit = go && (kind == AK_WORD_WR);

  cpisa_wbuf #(.BYTE_W(BYTE_W)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load      (wb_load),
    .load_byte (dec_byte),
    .commit    (wb_commit),
    .low_byte  (held_low),
    .valid     (held_valid)
  );

  // captured access
  logic              cap_write_q, cap_write_d;
  logic              cap_wide_q,  cap_wide_d;
  logic [ISA_AW-1:0] cap_addr_q,  cap_addr_d;
  logic [ISA_DW-1:0] cap_dout_q,  cap_dout_d;
  logic [BYTE_W-1:0] cap_byte_q,  cap_byte_d;
  logic [ISA_DW-1:0] rd_q, rd_d;
  logic              cap_en, rd_en;

  always_comb begin
    cap_en      = go;
    cap_write_d = (kind == AK_BYTE_WR) || (kind == AK_WORD_WR);
    cap_wide_d  = (kind == AK_WORD_RD) || (kind == AK_WORD_WR);
    cap_addr_d  = dec_addr;
    cap_byte_d  = dec_byte;
    if (kind == AK_WORD_WR) cap_dout_d = {dec_byte, held_low};
    else                    cap_dout_d = {{(ISA_DW-BYTE_W){1'b0}}, dec_byte};
  end

  always_comb begin
    rd_en = sample;
    if (cap_write_q)     rd_d = {cap_byte_q, {(ISA_DW-BYTE_W){1'b0}}};
    else if (cap_wide_q) rd_d = isa_din;
    else                 rd_d = {isa_din[BYTE_W-1:0], {(ISA_DW-BYTE_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cap_write_q <= 1'b0;
      cap_wide_q  <= 1'b0;
      cap_addr_q  <= IO_BASE;
      cap_dout_q  <= '0;
      cap_byte_q  <= '0;
      rd_q        <= '0;
    end else begin
      if (cap_en) begin
        cap_write_q <= cap_write_d;
        cap_wide_q  <= cap_wide_d;
        cap_addr_q  <= cap_addr_d;
        cap_dout_q  <= cap_dout_d;
        cap_byte_q  <= cap_byte_d;
      end
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign isa_addr    = cap_addr_q;
  assign isa_dout    = cap_dout_q;
  assign isa_dout_en = drive_on && cap_write_q;
  assign isa_ior_n   = !(strobe_on && !cap_write_q);
  assign isa_iow_n   = !(strobe_on && cap_write_q);
  assign isa_wide    = drive_on && cap_wide_q;
  assign host_rdata  = rd_q;
  assign host_oe     = done;

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(!isa_ior_n && !isa_iow_n));

  p_base_fixed_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!isa_ior_n || !isa_iow_n) |-> (isa_addr[ISA_AW-1:REG_W] == IO_BASE[ISA_AW-1:REG_W]));

  p_bus_stable_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!isa_ior_n || !isa_iow_n) |-> ($stable(isa_addr) && $stable(isa_dout) && $stable(isa_wide)));

  p_wdata_driven_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !isa_iow_n |-> isa_dout_en);

  p_oe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    host_oe |-> (isa_ior_n && isa_iow_n && !isa_dout_en));

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_s_n |=> (isa_ior_n && isa_iow_n && !host_oe && !isa_dout_en));

endmodule

// File: tb/cpisa_bridge_test.sv
`timescale 1ns/1ps
module cpisa_bridge_test;

  localparam int PULSE = 3;

  logic        clk;
  logic        rst_n;
  logic        host_sel, host_stb, host_win, host_word_mode;
  logic [13:1] host_addr;
  logic [15:0] host_rdata;
  logic        host_oe;
  logic [9:0]  isa_addr;
  logic [15:0] isa_dout;
  logic        isa_dout_en;
  logic [15:0] isa_din;
  logic        isa_ior_n, isa_iow_n, isa_wide;

  int vec_cnt = 0;
  int bad_cnt = 0;
  bit finished = 0;

  cpisa_bridge #(.PULSE_CLKS(PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_stb(host_stb),
    .host_win(host_win), .host_addr(host_addr), .host_word_mode(host_word_mode),
    .host_rdata(host_rdata), .host_oe(host_oe), .isa_addr(isa_addr),
    .isa_dout(isa_dout), .isa_dout_en(isa_dout_en), .isa_din(isa_din),
    .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n), .isa_wide(isa_wide)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // peripheral model: read data is a function of the address
  assign isa_din = {~isa_addr[7:0], isa_addr[7:0] ^ 8'h5A};

  function automatic logic [15:0] din_for(input logic [4:0] rs);
    logic [7:0] lo;
    lo = {3'b000, rs};
    return {~lo, lo ^ 8'h5A};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // results of the last access
  logic [15:0] a_rd;
  int          a_len, a_gap;
  bit          a_setup_ok, a_saw_r, a_saw_w, a_stable;
  logic [9:0]  a_addr;
  logic [15:0] a_dout;
  bit          a_wide, a_den;

  task automatic host_access(input logic win, input logic wmode, input logic [4:0] rs,
                             input logic [7:0] byt, input int linger);
    logic [9:0]  prev_addr;
    logic [15:0] prev_dout;
    int last_low;
    bit in_low;
    bit extra;
    @(negedge clk);
    host_win = win; host_word_mode = wmode; host_addr = {rs, byt};
    host_sel = 1'b1; host_stb = 1'b1;
    prev_addr = isa_addr; prev_dout = isa_dout;
    a_len = 0; a_gap = -1; a_setup_ok = 1; a_saw_r = 0; a_saw_w = 0; a_stable = 1;
    a_wide = 0; a_den = 1; last_low = -1; in_low = 0;
    for (int i = 1; i < 60; i++) begin
      @(negedge clk);
      if (!isa_ior_n || !isa_iow_n) begin
        if (!in_low) begin
          a_setup_ok = (isa_addr == prev_addr) && (isa_dout == prev_dout);
          a_addr = isa_addr; a_dout = isa_dout; a_wide = isa_wide;
        end else if (isa_addr != a_addr || isa_dout != a_dout) a_stable = 0;
        if (!isa_ior_n) a_saw_r = 1;
        if (!isa_iow_n) begin a_saw_w = 1; if (!isa_dout_en) a_den = 0; end
        in_low = 1; a_len++; last_low = i;
      end
      if (host_oe) begin a_gap = i - last_low; break; end
      prev_addr = isa_addr; prev_dout = isa_dout;
    end
    a_rd = host_rdata;
    extra = 0;
    for (int k = 0; k < linger; k++) begin
      @(negedge clk);
      if (!host_oe || !isa_ior_n || !isa_iow_n) extra = 1;
    end
    if (linger > 0) chk(!extra, "R10 oe held with no new cycle", 32'(extra), 0);
    host_sel = 1'b0; host_stb = 1'b0;
    @(negedge clk);
    chk(!host_oe, "R10 oe drops after release", 32'(host_oe), 0);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(isa_ior_n && isa_iow_n && !host_oe && !isa_dout_en, "R1 idle in reset",
        {isa_ior_n, isa_iow_n, host_oe, isa_dout_en}, 4'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(isa_ior_n && isa_iow_n && !host_oe && !isa_dout_en, "R1 idle after reset",
        {isa_ior_n, isa_iow_n, host_oe, isa_dout_en}, 4'b1100);
  endtask

  task automatic t_byte_read(input logic [4:0] rs);
    host_access(1'b0, 1'b0, rs, 8'hC3, 0);
    chk(a_saw_r && !a_saw_w, "R3 read window gives IOR", {a_saw_r, a_saw_w}, 2'b10);
    chk(a_addr == (10'h300 | 10'(rs)), "R2 register select", a_addr, 10'h300 | 10'(rs));
    chk(a_rd == {din_for(rs)[7:0], 8'h00}, "R4 byte read data", a_rd, {din_for(rs)[7:0], 8'h00});
    chk(!a_wide, "R4 byte read narrow", a_wide, 0);
    chk(a_len == PULSE, "R6 strobe width", a_len, PULSE);
    chk(a_setup_ok && a_stable, "R6 setup and stability", {a_setup_ok, a_stable}, 2'b11);
    chk(a_gap == 2, "R6 hold before oe", a_gap, 2);
  endtask

  task automatic t_byte_write(input logic [4:0] rs, input logic [7:0] byt);
    host_access(1'b1, 1'b0, rs, byt, 0);
    chk(a_saw_w && !a_saw_r, "R3 write window gives IOW", {a_saw_r, a_saw_w}, 2'b01);
    chk(a_addr == (10'h300 | 10'(rs)), "R2 write register select", a_addr, 10'h300 | 10'(rs));
    chk(a_dout[7:0] == byt && a_den && !a_wide, "R5 write byte driven",
        {a_den, a_wide, a_dout[7:0]}, {1'b1, 1'b0, byt});
    chk(a_rd == {byt, 8'h00}, "R5 write echo", a_rd, {byt, 8'h00});
    chk(a_len == PULSE && a_gap == 2, "R6 write strobe timing", {a_len[7:0], a_gap[7:0]}, {8'(PULSE), 8'd2});
  endtask

  task automatic t_word_read(input logic [4:0] rs);
    host_access(1'b0, 1'b1, rs, 8'h11, 0);
    chk(a_saw_r && a_wide, "R7 wide read cycle", {a_saw_r, a_wide}, 2'b11);
    chk(a_rd == din_for(rs), "R7 word read data", a_rd, din_for(rs));
  endtask

  task automatic t_word_write(input logic [4:0] rs, input logic [7:0] lo, input logic [7:0] hi);
    host_access(1'b0, 1'b1, rs, lo, 0);
    host_access(1'b1, 1'b1, rs, hi, 0);
    chk(a_saw_w && a_wide && a_den, "R8 wide write cycle", {a_saw_w, a_wide, a_den}, 3'b111);
    chk(a_dout == {hi, lo}, "R8 word write data", a_dout, {hi, lo});
    chk(a_rd == {hi, 8'h00}, "R8 word write echo", a_rd, {hi, 8'h00});
    host_access(1'b1, 1'b1, rs, 8'h77, 0);
    chk(a_dout == 16'h7700, "R9 low byte cleared after commit", a_dout, 16'h7700);
  endtask

  task automatic t_reset_clears_hold;
    host_access(1'b0, 1'b1, 5'd4, 8'hEE, 0);
    do_reset();
    host_access(1'b1, 1'b1, 5'd4, 8'h21, 0);
    chk(a_dout == 16'h2100, "R9 R1 reset empties holding register", a_dout, 16'h2100);
  endtask

  initial begin
    host_sel = 0; host_stb = 0; host_win = 0; host_word_mode = 0; host_addr = '0;
    do_reset();
    t_byte_read(5'd0);
    t_byte_read(5'd31);
    t_byte_read(5'd10);
    t_byte_write(5'd1, 8'hA5);
    t_byte_write(5'd30, 8'h00);
    t_byte_write(5'd16, 8'hFF);
    t_word_read(5'd7);
    t_word_read(5'd0);
    t_word_write(5'd2, 8'h3C, 8'hC4);
    t_word_write(5'd29, 8'hFF, 8'h01);
    host_access(1'b0, 1'b0, 5'd5, 8'h00, 5);
    chk(a_rd == {din_for(5'd5)[7:0], 8'h00}, "R10 data held while lingering", a_rd, {din_for(5'd5)[7:0], 8'h00});
    t_reset_clears_hold();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vec_cnt++; bad_cnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  end

endmodule